// File: doc/BRIEF.md
# Two-stage UART baud generator

This block turns the system clock into the timing pulses a UART transmitter and receiver need. A source enable is picked first: either an internal enable that fires on every second system clock, or the rising edges of an external strobe that is already synchronous to the system clock. That enable is divided by a programmable time constant, then optionally by a fixed factor of sixteen. The result is the oversample tick, sixteen per bit. A final divide-by-sixteen gives the bit tick.

The 16-bit divisor word holds the time constant in its upper twelve bits and the prescale select in bit 0. The oversample rate is source / ((TC + 1) × 16^P), where TC is the time constant and P is the prescale select. The bit rate is one sixteenth of that.

A two-state controller watches the divisor word and the source select. When either one changes, the controller spends one cycle in `ST_FLUSH` and clears every counter. Counting then resumes in `ST_RUN` at the new rate, so no count that started at the old rate can finish.

The controller has two states and three transitions:
- Reset leads to `ST_FLUSH`.
- `ST_FLUSH` always moves to `ST_RUN` after one cycle.
- `ST_RUN` returns to `ST_FLUSH` on the first clock edge that samples a divisor word or source select different from the one held.

Top module: `baud_gen_2stage`

## Requirements
- R1: While reset is asserted, `os_tick_o` and `bit_tick_o` are both low.
- R2: With the internal source, an oversample tick occurs every 2 × (TC + 1) × (16 if P = 1, else 1) system clock cycles.
- R3: The bit tick is high only in a cycle where the oversample tick is also high, and it occurs on every sixteenth oversample tick.
- R4: Each tick is high for exactly one system clock cycle and is never high in two consecutive cycles.
- R5: TC = 0 is legal and divides by one in the first stage. With the internal source and P = 0, this gives a tick every 2 cycles.
- R6: A change of the divisor word or the source select restarts all counters. If P is the new tick period and the change is sampled at clock edge 0, the first oversample tick appears after edge P + 1 and the first bit tick after edge 16P + 1. No tick appears in the cycle that follows the flush.
- R7: With the external source selected (`src_ext_sel_i` = 1), one count is taken per cycle in which `ext_clk_en_i` is high after being low in the cycle before. A strobe held high counts once. The internal half-rate enable has no effect in this mode.
- R8: The time constant is taken from divisor bits [15:4] and the prescale select from bit 0. Divisor bits [3:1] have no effect on the rate.
- R9: Divisor 0x0230 gives an oversample period of 72 cycles and a bit period of 1152 cycles. Divisor 0x1B00 gives an oversample period of 866 cycles. With a 133 MHz system clock these are about 115200 and 9600 baud.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ext_sel_i | input | 1 | 0: internal half-rate enable; 1: external strobe edges |
| ext_clk_en_i | input | 1 | External clock-enable strobe, synchronous to `clk` |
| divisor_i | input | 16 | [15:4] time constant, [0] prescale select (1 = divide by 16) |
| os_tick_o | output | 1 | One-cycle oversample tick (16 per bit) |
| bit_tick_o | output | 1 | One-cycle bit tick |

## Verification
On every cycle, assertions check four things:
- Each tick stays one cycle wide.
- A bit tick only lands on an oversample tick.
- No stage counter runs past its limit.
- The cycle after a flush is quiet, and in external mode every oversample tick follows a sampled high strobe.

The exact periods for each divisor, the restart latency after a change, the field positions and the example rates can only be shown by the bench's scenarios. The same holds for counting one edge for a held strobe and for the internal enable having no effect in external mode: the bench measures these as tick spacing and tick counts at the outputs.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    typedef enum logic [0:0] {
        ST_FLUSH = 1'b0,
        ST_RUN   = 1'b1
    } bg_state_e;
endpackage

// File: rtl/bg_src_enable.sv
module bg_src_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic sel_ext_i,
    input  logic ext_i,
    output logic src_en_o
);
    logic phase_q;
    logic ext_q;

    // Internal half-rate enable: toggles every cycle, restarted by a flush.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (clear_i) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    // Previous external strobe value, for rising-edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_i;
        end
    end

    always_comb begin
        if (!run_i) begin
            src_en_o = 1'b0;
        end else if (sel_ext_i) begin
            src_en_o = ext_i & ~ext_q;
        end else begin
            src_en_o = phase_q;
        end
    end
endmodule

// File: rtl/bg_div_stage.sv
module bg_div_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         en_i,
    input  logic         bypass_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;
    logic         at_limit;

    assign at_limit = (cnt_q == limit_i);
    assign tick_o   = en_i & (bypass_i | at_limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            if (bypass_i || at_limit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: the count never passes the programmed limit between flushes.
    assert_no_overflow_R2: assert property (
        @(posedge clk) disable iff (!rst_n || clear_i)
        (cnt_q <= limit_i)
    );
endmodule

// File: rtl/baud_gen_2stage.sv
module baud_gen_2stage
    import baud_gen_pkg::*;
#(
    parameter int TC_W     = 12,
    parameter int PRE_LOG2 = 4,
    parameter int OS_LOG2  = 4,
    localparam int DIV_W   = TC_W + PRE_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_ext_sel_i,
    input  logic             ext_clk_en_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             os_tick_o,
    output logic             bit_tick_o
);
    bg_state_e         state_q;
    bg_state_e         state_d;
    logic [TC_W-1:0]   tc_q;
    logic              pre_q;
    logic              sel_q;
    logic              cfg_change;
    logic              clear;
    logic              run;
    logic              src_en;
    logic              s1_tick;
    logic              os_comb;
    logic              bit_comb;
    logic [TC_W-1:0]   tc_in;
    logic              pre_in;
    logic              unused_pre_bits;

    // Field split: time constant on top, prescale select in bit 0.
    assign tc_in           = divisor_i[DIV_W-1 -: TC_W];
    assign pre_in          = divisor_i[0];
    assign unused_pre_bits = ^divisor_i[PRE_LOG2-1:1];

    // Configuration copy, refreshed every cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q  <= '0;
            pre_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            tc_q  <= tc_in;
            pre_q <= pre_in;
            sel_q <= src_ext_sel_i;
        end
    end

    assign cfg_change = (tc_in != tc_q) || (pre_in != pre_q) ||
                        (src_ext_sel_i != sel_q);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLUSH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLUSH: state_d = ST_RUN;
            ST_RUN:   state_d = cfg_change ? ST_FLUSH : ST_RUN;
            default:  state_d = ST_FLUSH;
        endcase
    end

    // State decode.
    always_comb begin
        clear = 1'b0;
        run   = 1'b0;
        unique case (state_q)
            ST_FLUSH: clear = 1'b1;
            ST_RUN:   run   = 1'b1;
            default:  clear = 1'b1;
        endcase
    end

    bg_src_enable u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .run_i     (run),
        .sel_ext_i (sel_q),
        .ext_i     (ext_clk_en_i),
        .src_en_o  (src_en)
    );

    bg_div_stage #(.W(TC_W)) u_tc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .en_i     (src_en),
        .bypass_i (1'b0),
        .limit_i  (tc_q),
        .tick_o   (s1_tick)
    );

    bg_div_stage #(.W(PRE_LOG2)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .en_i     (s1_tick),
        .bypass_i (~pre_q),
        .limit_i  ({PRE_LOG2{1'b1}}),
        .tick_o   (os_comb)
    );

    bg_div_stage #(.W(OS_LOG2)) u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .en_i     (os_comb),
        .bypass_i (1'b0),
        .limit_i  ({OS_LOG2{1'b1}}),
        .tick_o   (bit_comb)
    );

    // Registered, glitch-free tick outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_tick_o  <= 1'b0;
            bit_tick_o <= 1'b0;
        end else begin
            os_tick_o  <= os_comb;
            bit_tick_o <= bit_comb;
        end
    end

    // R4: ticks are single-cycle pulses.
    assert_os_pulse_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        os_tick_o |=> !os_tick_o
    );

    assert_bit_pulse_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        bit_tick_o |=> !bit_tick_o
    );

    // R3: a bit tick always coincides with an oversample tick.
    assert_bit_in_os_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> os_tick_o
    );

    // R6: the cycle after a flush carries no tick.
    assert_flush_quiet_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (!os_tick_o && !bit_tick_o)
    );

    // R7: in external mode a tick needs a sampled high strobe.
    assert_ext_edge_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (os_tick_o && sel_q && $past(sel_q)) |-> $past(ext_clk_en_i)
    );
endmodule

// File: tb/tb_baud_gen_2stage.sv
module tb_baud_gen_2stage;
    localparam int LIM = 20000;
    localparam int NV  = 8;
    // Vectors: R5 (0x0000, 0x0001), R8 (0x0010, 0x000E), R9 (0x0230, 0x1B00), R2 all.
    localparam logic [15:0] V_DIV [NV] = '{16'h0000, 16'h0010, 16'h0001, 16'h000E,
                                           16'h0011, 16'h0230, 16'h1B00, 16'hFFF0};
    localparam int          V_PER [NV] = '{2, 4, 32, 2, 64, 72, 866, 8192};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel;
    logic        ext;
    logic [15:0] div;
    logic        os_t;
    logic        bit_t;
    int          n_chk  = 0;
    int          n_err  = 0;
    int          os_seen = 0;

    always #4 clk = ~clk;

    baud_gen_2stage dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_ext_sel_i (sel),
        .ext_clk_en_i  (ext),
        .divisor_i     (div),
        .os_tick_o     (os_t),
        .bit_tick_o    (bit_t)
    );

    always @(negedge clk) if (os_t) os_seen++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges_to_os(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!os_t && n < LIM);
    endtask

    task automatic edges_to_bit(output int n, output int os_n);
        n = 0; os_n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
            if (os_t) os_n++;
        end while (!bit_t && n < LIM);
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext = 1'b1;
        @(negedge clk); ext = 1'b0;
        @(negedge clk); #1;
    endtask

    initial begin
        int lat, per, osn, base;
        rst_n = 1'b0; sel = 1'b0; ext = 1'b0; div = 16'hFFF0;
        repeat (5) begin
            @(negedge clk);
            check(!os_t && !bit_t, "R1 ticks low in reset", {os_t, bit_t}, 0);
        end
        @(negedge clk); rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // Table walk: restart latency, period, pulse width.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk); div = V_DIV[i];
            @(posedge clk);
            edges_to_os(lat);
            check(lat == V_PER[i] + 1, "R6 restart latency", lat, V_PER[i] + 1);
            @(posedge clk); @(negedge clk);
            check(!os_t, "R4 one-cycle os tick", os_t, 0);
            per = 1;
            while (!os_t && per < LIM) begin
                @(posedge clk); per++;
                @(negedge clk);
            end
            check(per == V_PER[i], "R2 R5 R8 R9 os period", per, V_PER[i]);
        end

        // Bit tick: latency, coincidence, 16 os ticks per bit.
        @(negedge clk); div = 16'h0230;
        @(posedge clk);
        edges_to_bit(lat, osn);
        check(lat == 16 * 72 + 1, "R6 bit tick latency", lat, 16 * 72 + 1);
        check(os_t == 1'b1, "R3 bit tick on os tick", os_t, 1);
        @(posedge clk); @(negedge clk);
        check(!bit_t, "R4 one-cycle bit tick", bit_t, 0);
        per = 1; osn = 0;
        while (!bit_t && per < LIM) begin
            @(posedge clk); per++;
            @(negedge clk);
            if (os_t) osn++;
        end
        check(per == 1152, "R9 bit period", per, 1152);
        check(osn == 16, "R3 os ticks per bit", osn, 16);

        // External source mode, time constant 2.
        @(negedge clk); sel = 1'b1; div = 16'h0020;
        repeat (50) @(negedge clk);
        #1 base = os_seen;
        repeat (100) @(negedge clk);
        #1 check(os_seen - base == 0, "R7 internal enable ignored", os_seen - base, 0);
        pulse_ext(); pulse_ext();
        check(os_seen - base == 0, "R7 two edges no tick", os_seen - base, 0);
        pulse_ext();
        check(os_seen - base == 1, "R7 third edge ticks", os_seen - base, 1);
        repeat (6) pulse_ext();
        check(os_seen - base == 3, "R7 nine edges", os_seen - base, 3);
        @(negedge clk); ext = 1'b1;
        repeat (20) @(negedge clk);
        ext = 1'b0;
        pulse_ext();
        check(os_seen - base == 3, "R7 held strobe counts once", os_seen - base, 3);
        pulse_ext();
        check(os_seen - base == 4, "R7 held plus two edges", os_seen - base, 4);

        // Source change restarts at internal rate.
        @(negedge clk); sel = 1'b0;
        @(posedge clk);
        edges_to_os(lat);
        check(lat == 7, "R6 source change restart", lat, 7);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule